// File: doc/BRIEF.md
# SPI Master with Slave-Ready Gating

This block is a single-slave SPI master for full-duplex word exchange. A host loads a transmit word and pulses a start strobe. The block pulls chip select low and waits a programmable number of settle cycles. It then holds the serial clock at its idle level until the slave pulls an active-low ready line low. Only then does it clock out one word, most significant bit first, while it shifts in the slave's reply. Clock polarity and phase are chosen at run time. The serial clock half-period is a run-time count of system clock cycles.

When a word finishes, the host either lets the block release chip select, or asks it to continue. If it continues, the next transmit word is loaded and chip select stays low. The block waits for the ready line again before the next word. Each received word is presented together with a one-cycle done pulse.

Top module: `spi_rdy_master`

## Requirements
- R1: While reset is asserted and after it, with no start, cs_no is 1, busy_o and done_o are 0, and sclk_o equals cpol_i.
- R2: A word is exchanged MSB first. mosi_o presents tx_word_i bit WORD_W-1 first. rx_word_o holds the miso_i bits in arrival order, with the first bit at position WORD_W-1.
- R3: Each word has exactly WORD_W clock pulses. With cpha_i=0, the master samples miso_i on the idle-to-active edge and changes mosi_o on the active-to-idle edge. With cpha_i=1, mosi_o changes on the idle-to-active edge and miso_i is sampled on the active-to-idle edge. After the word, sclk_o returns to cpol_i.
- R4: sclk_o is at the cpol_i level whenever cs_no falls, and it does not toggle while cs_no is high.
- R5: Suppose rdy_ni is already low. Then the first sclk_o edge comes exactly setup_cyc_i + half_div_i + 1 system cycles after cs_no falls, where a half_div_i of 0 counts as 1.
- R6: While rdy_ni is high before a word, sclk_o does not toggle and cs_no stays low. This holds before the first word and between continued words.
- R7: Consecutive sclk_o edges within a word are exactly half_div_i system cycles apart. A value of 0 is treated as 1.
- R8: done_o is high for exactly one cycle per word, one system cycle after the sclk_o edge on which the last bit is sampled. rx_word_o is valid from that cycle on.
- R9: cont_i is sampled in the cycle after the final edge of a word. If it is 1, cs_no stays low, tx_word_i is loaded and the block waits for ready. If it is 0, cs_no rises one system cycle after the final sclk_o edge.
- R10: busy_o is high from the cycle after an accepted start until cs_no rises. A start_i pulse while busy_o is high has no effect on the word, the pulse count or chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing edge |
| half_div_i | input | DIV_W | Serial clock half-period in system cycles (0 treated as 1) |
| setup_cyc_i | input | SETUP_W | Settle cycles after chip select falls |
| start_i | input | 1 | Start strobe, accepted when idle |
| cont_i | input | 1 | Keep chip select low and run another word |
| tx_word_i | input | WORD_W | Word to transmit |
| rx_word_o | output | WORD_W | Last received word |
| done_o | output | 1 | One-cycle pulse per completed word |
| busy_o | output | 1 | Transfer in progress |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to slave |
| miso_i | input | 1 | Serial data from slave |
| rdy_ni | input | 1 | Slave ready, active low |

## Verification
The hardest state to reach is a continued transfer that stalls between words. Chip select must stay low, the first word must already be reported, and the ready line must be raised at the moment the master starts waiting. For cpha_i=1 the continuation flag is sampled before the done pulse appears. The bench therefore holds cont_i high from the start and lowers it on the first done pulse. On that same pulse it drives rdy_ni high, holds it for many cycles and counts clock edges, then releases it and checks both words. A slave model that reacts to sclk_o edges in every mode supplies the reply data. It also records what the master sent, so the exchange is checked in both directions.

// File: rtl/spi_rdy_pkg.sv
package spi_rdy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_WAIT  = 3'd2,
    ST_XFER  = 3'd3,
    ST_END   = 3'd4
  } spi_st_e;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (half_i == '0) ? DIV_W'(1) : half_i;
  assign tick_o = en_i && (cnt_q == lim - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end

  // R7: with a half period above one cycle, ticks never come back to back
  a_r7_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && half_i > DIV_W'(1) && $stable(half_i)) |=> !tick_o);
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] capture_o
);
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_q <= '0;
    else if (load_i)  tx_q <= load_word_i;
    else if (shift_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (sample_i) rx_q <= {rx_q[WORD_W-2:0], miso_i};
  end

  assign mosi_o    = tx_q[WORD_W-1];
  assign capture_o = {rx_q[WORD_W-2:0], miso_i};

  // R2: each shift brings the next lower bit onto the data line
  a_r2_msb_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> mosi_o == $past(tx_q[WORD_W-2]));
endmodule

// File: rtl/spi_rdy_master.sv
module spi_rdy_master
  import spi_rdy_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int DIV_W   = 8,
  parameter int SETUP_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic [DIV_W-1:0]   half_div_i,
  input  logic [SETUP_W-1:0] setup_cyc_i,
  input  logic               start_i,
  input  logic               cont_i,
  input  logic [WORD_W-1:0]  tx_word_i,
  output logic [WORD_W-1:0]  rx_word_o,
  output logic               done_o,
  output logic               busy_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  input  logic               miso_i,
  input  logic               rdy_ni
);
  localparam int EDGES = 2 * WORD_W;
  localparam int EC_W  = $clog2(EDGES);

  spi_st_e           st_q;
  logic [SETUP_W-1:0] setup_q;
  logic [EC_W-1:0]   edge_q;
  logic              ph_q;
  logic              last_samp_q;
  logic              done_q;
  logic [WORD_W-1:0] rx_q;

  logic              tick;
  logic              lead;
  logic              final_edge;
  logic              samp_edge;
  logic              shift_edge;
  logic              last_samp;
  logic [EC_W-1:0]   last_samp_idx;
  logic              load;
  logic [WORD_W-1:0] capture;

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st_q == ST_XFER),
    .half_i (half_div_i),
    .tick_o (tick)
  );

  assign lead          = ~edge_q[0];
  assign final_edge    = (edge_q == EC_W'(EDGES - 1));
  assign last_samp_idx = cpha_i ? EC_W'(EDGES - 1) : EC_W'(EDGES - 2);
  assign samp_edge     = tick && (cpha_i ? ~lead : lead);
  // cpha=1 skips the first leading edge: the MSB is already on the line
  assign shift_edge    = tick && (cpha_i ? (lead && edge_q != '0) : (~lead && ~final_edge));
  assign last_samp     = samp_edge && (edge_q == last_samp_idx);
  assign load          = ((st_q == ST_IDLE) && start_i) || ((st_q == ST_END) && cont_i);

  spi_shift_unit #(.WORD_W(WORD_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_word_i (tx_word_i),
    .shift_i     (shift_edge),
    .sample_i    (samp_edge),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .capture_o   (capture)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      setup_q <= '0;
      edge_q  <= '0;
      ph_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          setup_q <= setup_cyc_i - SETUP_W'(1);
          st_q    <= (setup_cyc_i == '0) ? ST_WAIT : ST_SETUP;
        end
        ST_SETUP: begin
          if (setup_q == '0) st_q <= ST_WAIT;
          else               setup_q <= setup_q - SETUP_W'(1);
        end
        ST_WAIT: if (!rdy_ni) begin
          edge_q <= '0;
          st_q   <= ST_XFER;
        end
        ST_XFER: if (tick) begin
          ph_q   <= ~ph_q;
          edge_q <= edge_q + EC_W'(1);
          if (final_edge) st_q <= ST_END;
        end
        ST_END:  st_q <= cont_i ? ST_WAIT : ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_samp_q <= 1'b0;
      done_q      <= 1'b0;
      rx_q        <= '0;
    end else begin
      last_samp_q <= last_samp;
      done_q      <= last_samp_q;
      if (last_samp) rx_q <= capture;
    end
  end

  assign sclk_o    = ph_q ^ cpol_i;
  assign cs_no     = (st_q == ST_IDLE);
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign rx_word_o = rx_q;

  // R4: the clock phase is back at idle whenever the slave is deselected
  a_r4_idle_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !ph_q);

  // R6: no clock edge while waiting for the slave
  a_r6_hold_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && $stable(cpol_i)) |=> $stable(sclk_o));

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9: chip select cannot rise in the middle of a word
  a_r9_cs_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_SETUP, ST_WAIT, ST_XFER}) |=> !cs_no);

  // R3: data output holds across sampling edges
  a_r3_stable_at_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_edge |=> $stable(mosi_o));
endmodule

// File: tb/spi_rdy_master_tb_top.sv
module spi_rdy_master_tb_top;
  localparam int W = 8;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [7:0] div;
    logic [7:0] setup;
    logic [7:0] tx;
    logic [7:0] slv;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 1'b0, 8'd2, 8'd3, 8'hA5, 8'h3C},
    '{1'b0, 1'b1, 8'd1, 8'd0, 8'h81, 8'h7E},
    '{1'b1, 1'b0, 8'd3, 8'd1, 8'hFF, 8'h00},
    '{1'b1, 1'b1, 8'd0, 8'd2, 8'h00, 8'hFF},
    '{1'b0, 1'b0, 8'd1, 8'd0, 8'hC3, 8'h96},
    '{1'b1, 1'b1, 8'd4, 8'd5, 8'h5A, 8'hE1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0;
  logic [7:0] half_div = 8'd1, setup_cyc = 8'd0;
  logic start = 1'b0, cont = 1'b0, rdy_n = 1'b0, miso = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic [W-1:0] rx_word_o;
  logic done_o, busy_o, sclk_o, cs_no, mosi_o;

  spi_rdy_master #(.WORD_W(W), .DIV_W(8), .SETUP_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cpol_i(cpol), .cpha_i(cpha),
    .half_div_i(half_div), .setup_cyc_i(setup_cyc), .start_i(start),
    .cont_i(cont), .tx_word_i(tx_word), .rx_word_o(rx_word_o),
    .done_o(done_o), .busy_o(busy_o), .sclk_o(sclk_o), .cs_no(cs_no),
    .mosi_o(mosi_o), .miso_i(miso), .rdy_ni(rdy_n)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor and slave model, evaluated away from the active edge
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  int edges, leads, first_edge_cyc, prev_edge_cyc, last_samp_cyc;
  int cs_fall_cyc, cs_rise_cyc, cs_rises, idle_bad, div_bad, d_exp;
  int done_cnt, done_bad;
  bit first_seen;
  logic [W-1:0] rx_seen [0:1];
  logic [W-1:0] s_words [0:1];
  logic [W-1:0] s_rxw [0:1];
  logic [W-1:0] s_rx;
  logic s_wi;
  int s_oidx, s_nsamp;

  task automatic clear_mon();
    edges = 0; leads = 0; first_seen = 0; cs_rises = 0; idle_bad = 0;
    div_bad = 0; done_cnt = 0; done_bad = 0; last_samp_cyc = -10;
    rx_seen[0] = '0; rx_seen[1] = '0; s_rxw[0] = '0; s_rxw[1] = '0;
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_cs && !cs_no) begin
        cs_fall_cyc = cyc;
        if (sclk_o != cpol) idle_bad++;
        s_wi = 1'b0; s_oidx = 0; s_nsamp = 0; s_rx = '0;
        miso = s_words[0][W-1];
      end
      if (!prev_cs && cs_no) begin
        cs_rises++;
        cs_rise_cyc = cyc;
      end
      if (cs_no && sclk_o != cpol) idle_bad++;
      if (!cs_no && sclk_o != prev_sclk) begin
        automatic bit lead = (sclk_o != cpol);
        edges++;
        if (lead) leads++;
        if (!first_seen) begin
          first_seen = 1;
          first_edge_cyc = cyc;
        end else if (cyc - prev_edge_cyc != d_exp) div_bad++;
        prev_edge_cyc = cyc;
        if (lead != cpha) begin
          last_samp_cyc = cyc;
          s_rx = {s_rx[W-2:0], mosi_o};
          s_nsamp++;
          if (s_nsamp % W == 0) s_rxw[((s_nsamp / W) - 1) % 2] = s_rx;
          if (cpha) begin
            s_oidx++;
            if (s_oidx == W) begin s_oidx = 0; s_wi = ~s_wi; end
          end
        end else begin
          if (!cpha) begin
            s_oidx++;
            if (s_oidx == W) begin s_oidx = 0; s_wi = ~s_wi; end
          end
          miso = s_words[s_wi][W-1-s_oidx];
        end
      end
      if (done_o) begin
        if (cyc != last_samp_cyc + 1) done_bad++;
        if (done_cnt < 2) rx_seen[done_cnt] = rx_word_o;
        done_cnt++;
      end
    end
    prev_cs = cs_no;
    prev_sclk = sclk_o;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic setup_cfg(input vec_t v);
    @(negedge clk);
    cpol = v.cpol; cpha = v.cpha; half_div = v.div; setup_cyc = v.setup;
    tx_word = v.tx; s_words[0] = v.slv; s_words[1] = v.slv;
    d_exp = (v.div == 0) ? 1 : int'(v.div);
    clear_mon();
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk(cs_no == 1'b1, "R1 cs_no in reset", cs_no, 1);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 busy/done in reset", {busy_o, done_o}, 0);
    chk(sclk_o == cpol, "R1 sclk idle in reset", sclk_o, cpol);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_no == 1'b1 && busy_o == 1'b0, "R1 idle after reset", {cs_no, busy_o}, 2);

    // table-driven single words, all four modes
    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      setup_cfg(v);
      pulse_start();
      chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
      wait_idle();
      chk(rx_seen[0] == v.slv, "R2 received word", rx_seen[0], v.slv);
      chk(s_rxw[0] == v.tx, "R2 word seen by slave", s_rxw[0], v.tx);
      chk(leads == W && edges == 2 * W, "R3 pulse count", edges, 2 * W);
      chk(sclk_o == cpol && idle_bad == 0, "R4 idle level", idle_bad, 0);
      chk(first_edge_cyc - cs_fall_cyc == int'(v.setup) + d_exp + 1, "R5 setup gap",
          first_edge_cyc - cs_fall_cyc, int'(v.setup) + d_exp + 1);
      chk(div_bad == 0, "R7 half period", div_bad, 0);
      chk(done_cnt == 1 && done_bad == 0, "R8 done timing", {done_cnt, done_bad}, 1 << 0);
      chk(cs_rise_cyc - prev_edge_cyc == 1 && cs_rises == 1, "R9 release timing",
          cs_rise_cyc - prev_edge_cyc, 1);
      chk(busy_o == 1'b0, "R10 busy cleared", busy_o, 0);
    end

    // R6: ready held off before the first word
    setup_cfg('{1'b0, 1'b0, 8'd2, 8'd1, 8'h6D, 8'hB2});
    rdy_n = 1'b1;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(edges == 0 && cs_no == 1'b0, "R6 no clock while not ready", edges, 0);
    rdy_n = 1'b0;
    wait_idle();
    chk(rx_seen[0] == 8'hB2 && s_rxw[0] == 8'h6D, "R6 word after ready", rx_seen[0], 8'hB2);

    // R9 + R6: continued transfer with a stall between words
    setup_cfg('{1'b0, 1'b1, 8'd2, 8'd1, 8'h96, 8'h3C});
    s_words[1] = 8'hA7;
    cont = 1'b1;
    pulse_start();
    repeat (3) @(negedge clk);
    tx_word = 8'h4B;
    while (!done_o) @(negedge clk);
    cont = 1'b0;
    rdy_n = 1'b1;
    repeat (15) @(negedge clk);
    chk(edges == 2 * W && cs_no == 1'b0, "R6 stall between words", edges, 2 * W);
    rdy_n = 1'b0;
    wait_idle();
    chk(rx_seen[0] == 8'h3C && rx_seen[1] == 8'hA7, "R9 both words received",
        {rx_seen[0], rx_seen[1]}, 16'h3CA7);
    chk(s_rxw[0] == 8'h96 && s_rxw[1] == 8'h4B, "R9 both words sent",
        {s_rxw[0], s_rxw[1]}, 16'h964B);
    chk(cs_rises == 1 && leads == 2 * W, "R9 chip select held", cs_rises, 1);
    chk(done_cnt == 2 && done_bad == 0, "R8 done per word", done_cnt, 2);

    // R10: start while busy is ignored
    setup_cfg('{1'b1, 1'b0, 8'd2, 8'd0, 8'h1E, 8'hC5});
    pulse_start();
    repeat (4) @(negedge clk);
    tx_word = 8'hF0;
    pulse_start();
    wait_idle();
    chk(s_rxw[0] == 8'h1E, "R10 word unchanged by extra start", s_rxw[0], 8'h1E);
    chk(leads == W && cs_rises == 1 && busy_o == 1'b0, "R10 single word only", leads, W);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule